// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block is a small microprogrammed controller that moves a unit's working state into a context memory and back again. A host first fills a 256-word instruction store. It writes a start index to an index register and then pushes words through a data register, which steps the index by one after each write. A start pulse then runs the program from word 0, and the context position begins at 0.

Each 32-bit instruction does one thing. It can test or wait on a single flag, write a flag, copy a run of registers between the register-file port and the context-memory port, load a 20-bit bulk count, or raise a control pulse. A flag is named by a 7-bit index equal to bank*32+bit. Flag 0 gives the copy direction. Flag 104 always reads 1, so a branch on it is an unconditional jump. The flag file can also be written from outside, one bit at a time, by a write-enable vector.

The end code stops the sequencer. It then waits in the halted state until the next start pulse.

Top module: `cseq_top`

## Requirements
- R1: After the index register is written with 0 (host_wdata[7:0]), each data-register write stores host_wdata at the current index and then adds one to the index. A start pulse, accepted only while the sequencer is idle or halted, runs the stored program from word 0 with the context position at 0.
- R2: Bits 23:20 hold the opcode, and bits 31:24 must be zero for any opcode to act. Opcode 1 is a copy: bits 13:0 give a register offset and bits 19:14 give a count. When flag 0 is 1 (save), the copy reads the register file at offset, offset+1, and so on, and writes context memory at pos, pos+1, and so on, one word per cycle. The position then advances by the count.
- R3: When flag 0 is 0 (load), a copy reads context memory starting at the current position and writes the register file starting at the offset. The position advances by the count.
- R4: A copy with count 0 makes no transfers and leaves the position unchanged.
- R5: Opcode 2 places bits 19:0 into the bulk count output. The count does not change while the sequencer is idle or halted.
- R6: Opcode 4 is a branch with target in bits 15:8 and flag index in bits 6:0. If bit 7 is 0, the branch is taken when the flag is 1. If bit 7 is 1, it is taken when the flag is 0. A branch that is not taken, and every other instruction except a stalled wait, goes on to the next word.
- R7: Flag 104 always reads 1, and writes to it from a program are ignored.
- R8: Opcode 5 stalls, with the pointer unchanged and no other action, until the indexed flag equals bit 7.
- R9: Opcode 7 writes bit 7 into the indexed flag. If an external write hits the same flag in the same cycle, the program write wins. External writes to other flags in that cycle still take effect.
- R10: Opcode 6 with low byte 0x07, 0x09 or 0x0A pulses strb_swap, strb_cur or strb_ptr for exactly one cycle. At most one strobe is high at a time.
- R11: Opcode 6 with low byte 0x0E halts. The halted output then stays high, and no copy writes occur, until the next start.
- R12: After reset, the sequencer is idle (not running, not halted), every flag is 0 except flag 104, the bulk count is 0, and no strobe or write enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_idx_we | input | 1 | Write store index from host_wdata[7:0] |
| host_data_we | input | 1 | Write host_wdata into store, then step index |
| host_wdata | input | 32 | Host write data |
| seq_start | input | 1 | Start program at word 0 |
| flag_ext_we | input | 128 | Per-flag external write enable |
| flag_ext_val | input | 128 | Per-flag external write value |
| flag_out | output | 128 | Current flag file contents |
| rf_addr | output | 14 | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data for rf_addr |
| ctx_addr | output | 16 | Context-memory address |
| ctx_we | output | 1 | Context-memory write enable |
| ctx_wdata | output | 32 | Context-memory write data |
| ctx_rdata | input | 32 | Context-memory read data for ctx_addr |
| xfer_count | output | 20 | Bulk transfer count register |
| strb_swap | output | 1 | One-cycle pulse for control code 0x07 |
| strb_cur | output | 1 | One-cycle pulse for control code 0x09 |
| strb_ptr | output | 1 | One-cycle pulse for control code 0x0A |
| seq_running | output | 1 | Program is executing |
| seq_halted | output | 1 | Program reached its end code |

## Verification
A program flag write and an external write to the same flag can land on the same clock edge. The bench times this collision from a strobe. It runs a control pulse directly before a set of flag 7 to 1. One cycle after the pulse appears, it drives an external write of 0 to flag 7 and of 1 to flag 8. It then reads flag_out and expects flag 7 to hold the program value and flag 8 to hold the external one. A scoreboard separately checks that every copy write and strobe appears in program order and that skipped or untaken paths leave no events.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  localparam int unsigned INSTR_W    = 32;
  localparam int unsigned NFLAG      = 128;
  localparam int unsigned FIDX_W     = $clog2(NFLAG);
  localparam int unsigned FLAG_DIR   = 0;
  localparam int unsigned FLAG_TRUE  = 104;

  localparam logic [3:0] OP_COPY = 4'd1;
  localparam logic [3:0] OP_LCNT = 4'd2;
  localparam logic [3:0] OP_BRA  = 4'd4;
  localparam logic [3:0] OP_WAIT = 4'd5;
  localparam logic [3:0] OP_MISC = 4'd6;
  localparam logic [3:0] OP_SET  = 4'd7;

  localparam logic [7:0] MC_SWAP = 8'h07;
  localparam logic [7:0] MC_CUR  = 8'h09;
  localparam logic [7:0] MC_PTR  = 8'h0A;
  localparam logic [7:0] MC_END  = 8'h0E;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_COPY, S_HALT
  } seq_state_e;
endpackage

// File: rtl/cseq_store.sv
module cseq_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_idx_we,
  input  logic          host_data_we,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] widx;

  // host index register, steps after every data write
  always_ff @(posedge clk) begin
    if (rst) begin
      widx <= '0;
    end else if (host_idx_we) begin
      widx <= host_wdata[AW-1:0];
    end else if (host_data_we) begin
      widx <= widx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (host_data_we && !host_idx_we) begin
      mem[widx] <= host_wdata;
    end
  end

  // registered read port, block-RAM style
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cseq_flags.sv
module cseq_flags #(
  parameter int unsigned NFLAG     = 128,
  parameter int unsigned TRUE_IDX  = 104,
  localparam int unsigned IW       = $clog2(NFLAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prog_we,
  input  logic [IW-1:0]    prog_idx,
  input  logic             prog_val,
  input  logic [NFLAG-1:0] ext_we,
  input  logic [NFLAG-1:0] ext_val,
  output logic [NFLAG-1:0] flags
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    if (i == TRUE_IDX) begin : g_true
      logic unused_true;
      assign unused_true = ^{ext_we[i], ext_val[i]};
      assign flags[i] = 1'b1;
    end else begin : g_reg
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          bit_q <= 1'b0;
        end else if (prog_we && (prog_idx == IW'(i))) begin
          bit_q <= prog_val;
        end else if (ext_we[i]) begin
          bit_q <= ext_val[i];
        end
      end
      assign flags[i] = bit_q;
    end
  end
endmodule

// File: rtl/cseq_core.sv
module cseq_core
  import cseq_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned RF_AW  = 14,
  parameter int unsigned CTX_AW = 16,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned DW     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seq_start,
  output logic [AW-1:0]      ip,
  input  logic [INSTR_W-1:0] instr,
  input  logic [NFLAG-1:0]   flags,
  output logic               fl_we,
  output logic [FIDX_W-1:0]  fl_idx,
  output logic               fl_val,
  output logic [RF_AW-1:0]   rf_addr,
  output logic               rf_we,
  output logic [DW-1:0]      rf_wdata,
  input  logic [DW-1:0]      rf_rdata,
  output logic [CTX_AW-1:0]  ctx_addr,
  output logic               ctx_we,
  output logic [DW-1:0]      ctx_wdata,
  input  logic [DW-1:0]      ctx_rdata,
  output logic [CNT_W-1:0]   xfer_count,
  output logic               strb_swap,
  output logic               strb_cur,
  output logic               strb_ptr,
  output logic               seq_running,
  output logic               seq_halted
);
  localparam int unsigned CW = 6;

  seq_state_e state;
  logic [CTX_AW-1:0] pos, cptr;
  logic [RF_AW-1:0]  rptr;
  logic [CW-1:0]     cp_left, cp_len;
  logic              cp_save;

  // instruction fields
  logic              ins_ok;
  logic [3:0]        op;
  logic              ins_pol;
  logic [FIDX_W-1:0] ins_fidx;
  logic [AW-1:0]     ins_tgt;
  logic [RF_AW-1:0]  ins_reg;
  logic [CW-1:0]     ins_cnt;
  logic              flag_hit;
  logic [AW-1:0]     ip_inc;

  assign ins_ok   = (instr[31:24] == 8'h00);
  assign op       = instr[23:20];
  assign ins_pol  = instr[7];
  assign ins_fidx = instr[FIDX_W-1:0];
  assign ins_tgt  = instr[8 +: AW];
  assign ins_reg  = instr[RF_AW-1:0];
  assign ins_cnt  = instr[19:14];
  assign flag_hit = flags[ins_fidx];
  assign ip_inc   = ip + 1'b1;

  assign fl_we  = (state == S_EXEC) && ins_ok && (op == OP_SET);
  assign fl_idx = ins_fidx;
  assign fl_val = ins_pol;

  assign seq_running = (state == S_FETCH) || (state == S_EXEC) || (state == S_COPY);
  assign seq_halted  = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ip         <= '0;
      pos        <= '0;
      cptr       <= '0;
      rptr       <= '0;
      cp_left    <= '0;
      cp_len     <= '0;
      cp_save    <= 1'b0;
      rf_addr    <= '0;
      rf_we      <= 1'b0;
      rf_wdata   <= '0;
      ctx_addr   <= '0;
      ctx_we     <= 1'b0;
      ctx_wdata  <= '0;
      xfer_count <= '0;
      strb_swap  <= 1'b0;
      strb_cur   <= 1'b0;
      strb_ptr   <= 1'b0;
    end else begin
      rf_we     <= 1'b0;
      ctx_we    <= 1'b0;
      strb_swap <= 1'b0;
      strb_cur  <= 1'b0;
      strb_ptr  <= 1'b0;
      unique case (state)
        S_IDLE, S_HALT: begin
          if (seq_start) begin
            ip    <= '0;
            pos   <= '0;
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          ip    <= ip_inc;
          state <= S_FETCH;
          if (ins_ok) begin
            case (op)
              OP_COPY: begin
                if (ins_cnt != '0) begin
                  ip      <= ip;
                  state   <= S_COPY;
                  cp_left <= ins_cnt;
                  cp_len  <= ins_cnt;
                  cp_save <= flags[FLAG_DIR];
                  rptr    <= ins_reg;
                  cptr    <= pos;
                  if (flags[FLAG_DIR]) rf_addr <= ins_reg;
                  else                 ctx_addr <= pos;
                end
              end
              OP_LCNT: xfer_count <= instr[CNT_W-1:0];
              OP_BRA: begin
                if (flag_hit != ins_pol) ip <= ins_tgt;
              end
              OP_WAIT: begin
                if (flag_hit != ins_pol) begin
                  ip    <= ip;
                  state <= S_EXEC;
                end
              end
              OP_MISC: begin
                case (instr[7:0])
                  MC_SWAP: strb_swap <= 1'b1;
                  MC_CUR:  strb_cur  <= 1'b1;
                  MC_PTR:  strb_ptr  <= 1'b1;
                  MC_END:  state     <= S_HALT;
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
        S_COPY: begin
          if (cp_save) begin
            ctx_we    <= 1'b1;
            ctx_addr  <= cptr;
            ctx_wdata <= rf_rdata;
            cptr      <= cptr + 1'b1;
            rf_addr   <= rf_addr + 1'b1;
          end else begin
            rf_we     <= 1'b1;
            rf_addr   <= rptr;
            rf_wdata  <= ctx_rdata;
            rptr      <= rptr + 1'b1;
            ctx_addr  <= ctx_addr + 1'b1;
          end
          cp_left <= cp_left - 1'b1;
          if (cp_left == CW'(1)) begin
            pos   <= pos + CTX_AW'(cp_len);
            ip    <= ip_inc;
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cseq_top.sv
module cseq_top
  import cseq_pkg::*;
#(
  parameter int unsigned STORE_DEPTH = 256,
  parameter int unsigned RF_AW       = 14,
  parameter int unsigned CTX_AW      = 16,
  parameter int unsigned CNT_W       = 20,
  localparam int unsigned AW         = $clog2(STORE_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_idx_we,
  input  logic               host_data_we,
  input  logic [INSTR_W-1:0] host_wdata,
  input  logic               seq_start,
  input  logic [NFLAG-1:0]   flag_ext_we,
  input  logic [NFLAG-1:0]   flag_ext_val,
  output logic [NFLAG-1:0]   flag_out,
  output logic [RF_AW-1:0]   rf_addr,
  output logic               rf_we,
  output logic [31:0]        rf_wdata,
  input  logic [31:0]        rf_rdata,
  output logic [CTX_AW-1:0]  ctx_addr,
  output logic               ctx_we,
  output logic [31:0]        ctx_wdata,
  input  logic [31:0]        ctx_rdata,
  output logic [CNT_W-1:0]   xfer_count,
  output logic               strb_swap,
  output logic               strb_cur,
  output logic               strb_ptr,
  output logic               seq_running,
  output logic               seq_halted
);
  logic [AW-1:0]      ip;
  logic [INSTR_W-1:0] instr;
  logic               fl_we, fl_val;
  logic [FIDX_W-1:0]  fl_idx;

  cseq_store #(.DEPTH(STORE_DEPTH), .DW(INSTR_W)) u_store (
    .clk(clk), .rst(rst),
    .host_idx_we(host_idx_we), .host_data_we(host_data_we),
    .host_wdata(host_wdata),
    .rd_addr(ip), .rd_data(instr)
  );

  cseq_flags #(.NFLAG(NFLAG), .TRUE_IDX(FLAG_TRUE)) u_flags (
    .clk(clk), .rst(rst),
    .prog_we(fl_we), .prog_idx(fl_idx), .prog_val(fl_val),
    .ext_we(flag_ext_we), .ext_val(flag_ext_val),
    .flags(flag_out)
  );

  cseq_core #(
    .AW(AW), .RF_AW(RF_AW), .CTX_AW(CTX_AW), .CNT_W(CNT_W), .DW(32)
  ) u_core (
    .clk(clk), .rst(rst), .seq_start(seq_start),
    .ip(ip), .instr(instr), .flags(flag_out),
    .fl_we(fl_we), .fl_idx(fl_idx), .fl_val(fl_val),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ctx_addr(ctx_addr), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
    .xfer_count(xfer_count),
    .strb_swap(strb_swap), .strb_cur(strb_cur), .strb_ptr(strb_ptr),
    .seq_running(seq_running), .seq_halted(seq_halted)
  );
endmodule

// File: rtl/cseq_chk.sv
module cseq_chk #(
  parameter int unsigned CTX_AW = 16,
  parameter int unsigned CNT_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              seq_start,
  input logic              seq_running,
  input logic              seq_halted,
  input logic              ctx_we,
  input logic              rf_we,
  input logic [CTX_AW-1:0] ctx_addr,
  input logic              strb_swap,
  input logic              strb_cur,
  input logic              strb_ptr,
  input logic [CNT_W-1:0]  xfer_count
);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb_swap, strb_cur, strb_ptr}));

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (strb_swap || strb_cur || strb_ptr) |=> !(strb_swap || strb_cur || strb_ptr));

  p_port_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctx_we && rf_we));

  p_ctx_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ctx_we && $past(ctx_we)) |-> (ctx_addr == CTX_AW'($past(ctx_addr) + 1'b1)));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    seq_halted |-> (!ctx_we && !rf_we && !seq_running));

  p_halt_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (seq_halted && !seq_start) |=> seq_halted);

  p_count_still_r5: assert property (@(posedge clk) disable iff (rst)
    !seq_running |=> $stable(xfer_count));
endmodule

bind cseq_top cseq_chk #(.CTX_AW(CTX_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .seq_start(seq_start),
  .seq_running(seq_running), .seq_halted(seq_halted),
  .ctx_we(ctx_we), .rf_we(rf_we), .ctx_addr(ctx_addr),
  .strb_swap(strb_swap), .strb_cur(strb_cur), .strb_ptr(strb_ptr),
  .xfer_count(xfer_count)
);

// File: tb/cseq_top_test.sv
module cseq_top_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_idx_we = 1'b0, host_data_we = 1'b0;
  logic [31:0]  host_wdata = '0;
  logic         seq_start = 1'b0;
  logic [127:0] flag_ext_we = '0, flag_ext_val = '0;
  logic [127:0] flag_out;
  logic [13:0]  rf_addr;
  logic         rf_we;
  logic [31:0]  rf_wdata, rf_rdata;
  logic [15:0]  ctx_addr;
  logic         ctx_we;
  logic [31:0]  ctx_wdata, ctx_rdata;
  logic [19:0]  xfer_count;
  logic         strb_swap, strb_cur, strb_ptr, seq_running, seq_halted;

  int checks = 0;
  int errors = 0;

  logic [31:0] rmem [128];
  logic [31:0] cmem [64];
  logic [63:0] sbq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cseq_top uut (
    .clk(clk), .rst(rst),
    .host_idx_we(host_idx_we), .host_data_we(host_data_we), .host_wdata(host_wdata),
    .seq_start(seq_start), .flag_ext_we(flag_ext_we), .flag_ext_val(flag_ext_val),
    .flag_out(flag_out),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ctx_addr(ctx_addr), .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
    .xfer_count(xfer_count),
    .strb_swap(strb_swap), .strb_cur(strb_cur), .strb_ptr(strb_ptr),
    .seq_running(seq_running), .seq_halted(seq_halted)
  );

  // memory models behind the two data ports
  assign rf_rdata  = rmem[rf_addr[6:0]];
  assign ctx_rdata = cmem[ctx_addr[5:0]];
  always @(posedge clk) begin
    if (rf_we)  rmem[rf_addr[6:0]]  <= rf_wdata;
    if (ctx_we) cmem[ctx_addr[5:0]] <= ctx_wdata;
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard item: kind[63:60] 1=ctx write 2=rf write 3=strobe, addr[47:32], data[31:0]
  task automatic push(input logic [3:0] kind, input logic [15:0] addr, input logic [31:0] data);
    sbq.push_back({kind, 12'd0, addr, data});
  endtask

  task automatic take(input logic [63:0] got, input string tag);
    if (sbq.size() == 0) begin
      chk(1'b0, {tag, " unexpected event"}, got, 64'd0);
    end else begin
      logic [63:0] exp;
      exp = sbq.pop_front();
      chk(got == exp, tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ctx_we) take({4'd1, 12'd0, ctx_addr, ctx_wdata}, "R2 ctx write");
      if (rf_we)  take({4'd2, 12'd0, 2'b00, rf_addr, rf_wdata}, "R3 rf write");
      if (strb_swap) take({4'd3, 12'd0, 16'h0007, 32'd0}, "R10 strobe");
      if (strb_cur)  take({4'd3, 12'd0, 16'h0009, 32'd0}, "R10 strobe");
      if (strb_ptr)  take({4'd3, 12'd0, 16'h000A, 32'd0}, "R10 strobe");
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired act=running exp=halted");
    summary();
    $finish;
  end

  task automatic load_prog(input logic [31:0] p [17], input int n);
    @(negedge clk);
    host_idx_we = 1'b1; host_wdata = 32'd0;
    @(negedge clk);
    host_idx_we = 1'b0;
    for (int i = 0; i < n; i++) begin
      host_data_we = 1'b1; host_wdata = p[i];
      @(negedge clk);
    end
    host_data_we = 1'b0;
  endtask

  task automatic ext_flag(input int idx, input logic val);
    @(negedge clk);
    flag_ext_we[idx] = 1'b1; flag_ext_val[idx] = val;
    @(negedge clk);
    flag_ext_we = '0; flag_ext_val = '0;
  endtask

  task automatic go();
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
  endtask

  task automatic wait_halt(input string tag);
    for (int i = 0; i < 3000; i++) begin
      if (seq_halted) break;
      @(negedge clk);
    end
    chk(seq_halted, tag, {63'd0, seq_halted}, 64'd1);
  endtask

  logic [31:0] pa [17];
  logic [31:0] pb [17];

  initial begin
    for (int i = 0; i < 128; i++) rmem[i] = 32'hC0DE_0000 + 32'(i * 7);
    for (int i = 0; i < 64; i++)  cmem[i] = 32'h0;
    pa[0]  = 32'h0040_0305; // branch if flag5 set -> 3
    pa[1]  = 32'h0060_000E;
    pa[2]  = 32'h0060_000E;
    pa[3]  = 32'h0070_0080; // flag0 = 1 (save)
    pa[4]  = 32'h0010_C010; // copy 3 from 0x10
    pa[5]  = 32'h0021_2345; // count = 0x12345
    pa[6]  = 32'h0060_0007; // strobe swap
    pa[7]  = 32'h0010_8020; // copy 2 from 0x20
    pa[8]  = 32'h0070_0005; // flag5 = 0
    pa[9]  = 32'h0070_0068; // write 0 to flag104 (ignored)
    pa[10] = 32'h0050_0060; // wait flag96 == 0
    pa[11] = 32'h0040_0D68; // branch on flag104 -> 13
    pa[12] = 32'h0060_0009; // skipped
    pa[13] = 32'h0040_0F86; // branch if flag6 clear -> 15
    pa[14] = 32'h0060_000A; // skipped
    pa[15] = 32'h0060_000A; // strobe ptr
    pa[16] = 32'h0060_000E; // end
    pb[0]  = 32'h0070_0000; // flag0 = 0 (load)
    pb[1]  = 32'h0010_8030; // copy 2 to 0x30
    pb[2]  = 32'h0010_0040; // copy count 0
    pb[3]  = 32'h0010_4050; // copy 1 to 0x50
    pb[4]  = 32'h0040_0706; // branch if flag6 set (not taken)
    pb[5]  = 32'h0060_0007; // strobe swap
    pb[6]  = 32'h0070_0087; // flag7 = 1
    pb[7]  = 32'h0060_0009; // strobe cur
    pb[8]  = 32'h0060_000E; // end
    for (int i = 9; i < 17; i++) pb[i] = 32'h0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(flag_out == (128'd1 << 104), "R12 flags after reset", flag_out[63:0], 64'd0);
    chk(!seq_running && !seq_halted, "R12 idle after reset", {62'd0, seq_running, seq_halted}, 64'd0);
    chk(xfer_count == 20'd0 && !ctx_we && !rf_we, "R12 count/enables", {44'd0, xfer_count}, 64'd0);

    // program A: save direction
    load_prog(pa, 17);
    ext_flag(5, 1'b1);
    ext_flag(96, 1'b1);
    push(4'd1, 16'd0, rmem[16]);
    push(4'd1, 16'd1, rmem[17]);
    push(4'd1, 16'd2, rmem[18]);
    push(4'd3, 16'h0007, 32'd0);
    push(4'd1, 16'd3, rmem[32]);
    push(4'd1, 16'd4, rmem[33]);
    push(4'd3, 16'h000A, 32'd0);
    go();
    repeat (60) @(negedge clk);
    chk(!seq_halted && seq_running, "R8 stalled on wait", {63'd0, seq_halted}, 64'd0);
    chk(sbq.size() == 1, "R8 nothing past wait", 64'(sbq.size()), 64'd1);
    ext_flag(96, 1'b0);
    wait_halt("R1 program A reached end");
    chk(sbq.size() == 0, "R6 branch path events", 64'(sbq.size()), 64'd0);
    chk(xfer_count == 20'h12345, "R5 bulk count", {44'd0, xfer_count}, 64'h12345);
    chk(flag_out[0] == 1'b1 && flag_out[5] == 1'b0, "R9 program flag writes",
        {62'd0, flag_out[0], flag_out[5]}, 64'd2);
    chk(flag_out[104] == 1'b1, "R7 always-true flag", {63'd0, flag_out[104]}, 64'd1);
    repeat (10) @(negedge clk);
    chk(seq_halted && !seq_running, "R11 halt holds", {62'd0, seq_halted, seq_running}, 64'd2);

    // program B: load direction, zero copy, untaken branch, flag collision
    load_prog(pb, 9);
    push(4'd2, 16'h0030, cmem[0]);
    push(4'd2, 16'h0031, cmem[1]);
    push(4'd2, 16'h0050, cmem[2]);
    push(4'd3, 16'h0007, 32'd0);
    push(4'd3, 16'h0009, 32'd0);
    go();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (strb_swap) break;
    end
    @(negedge clk);
    flag_ext_we[7] = 1'b1; flag_ext_val[7] = 1'b0;
    flag_ext_we[8] = 1'b1; flag_ext_val[8] = 1'b1;
    @(negedge clk);
    flag_ext_we = '0; flag_ext_val = '0;
    chk(flag_out[7] == 1'b1, "R9 program write wins collision", {63'd0, flag_out[7]}, 64'd1);
    chk(flag_out[8] == 1'b1, "R9 other external write lands", {63'd0, flag_out[8]}, 64'd1);
    wait_halt("R11 program B reached end");
    chk(sbq.size() == 0, "R4 R6 load events complete", 64'(sbq.size()), 64'd0);
    chk(flag_out[0] == 1'b0, "R3 direction flag load", {63'd0, flag_out[0]}, 64'd0);
    chk(rmem[80] == cmem[2], "R4 zero copy kept position", {32'd0, rmem[80]}, {32'd0, cmem[2]});
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule